// File: doc/BRIEF.md
# Virtual Interrupt List Register Slot

This block is one slot of the table a hypervisor fills to show virtual interrupts to a guest CPU interface. The hypervisor writes the slot in a single cycle: a valid flag, a virtual interrupt ID, a two-bit lifecycle state, a link flag and a physical interrupt ID. Once written, the slot follows the guest. An acknowledge read takes a pending interrupt and returns its virtual ID in the same cycle. A later deactivate retires it.

When the link flag is set, the virtual interrupt stands for a physical interrupt that is held active at the distributor. A guest deactivate of a linked slot then produces a one-cycle request that carries the physical ID toward the distributor, so that the physical interrupt is retired as well.

The slot checks each hypervisor write and refuses two kinds of programming. The first is a linked slot that asks to be pending and active at once. The second is a link on an ID in the message-based range, which has no active state. A refused write leaves the slot as it was and raises a one-cycle error pulse.

Top module: `vlr_slot`

## Requirements
- R1: After reset the slot is empty: slot_valid, slot_state, slot_link, slot_vid, slot_pid, irq_present, ack_hit, wr_err and pdeact_req are all 0.
- R2: The state field uses 2'b00 inactive, 2'b01 pending, 2'b10 active and 2'b11 pending+active. An accepted write (wr_en high) loads valid, ID, state, link and physical ID, and these appear on the slot outputs after the next rising edge. irq_present is 1 exactly when the slot is valid and its state is 2'b01.
- R3: While wr_en is low, an acknowledge (ack high) on a valid slot in state 2'b01 sets ack_hit and drives ack_vid with the slot's virtual ID in the same cycle, and the state becomes 2'b10 after the edge. In any other state ack_hit and ack_vid are 0 and the slot does not change.
- R4: While wr_en is low, a deactivate (deact high) on a valid slot in state 2'b10 sets the state to 2'b00 after the edge.
- R5: A deactivate on a valid unlinked slot in state 2'b11 sets the state to 2'b01, so irq_present is 1 again.
- R6: A deactivate while the slot is invalid, inactive or pending leaves the slot unchanged and produces no pdeact_req.
- R7: A deactivate that retires a linked active slot raises pdeact_req for exactly the cycle after the edge, with pdeact_pid equal to the slot's physical ID. An unlinked slot never raises pdeact_req, and pdeact_pid is 0 whenever pdeact_req is 0.
- R8: A write with wr_link = 1 and wr_state = 2'b11 is refused. The slot keeps its previous contents and wr_err is 1 for the one cycle after the edge.
- R9: A write with wr_link = 1 and wr_vid at or above LPI_BASE is refused in the same way, with wr_err. A valid linked slot therefore never holds an ID in that range.
- R10: In a cycle with wr_en high, ack and deact are ignored, whether the write is accepted or refused. ack_hit is 0 and no pdeact_req follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Hypervisor write strobe |
| wr_valid | input | 1 | Valid flag to write |
| wr_vid | input | VID_W | Virtual interrupt ID to write |
| wr_state | input | 2 | Lifecycle state to write |
| wr_link | input | 1 | Link-to-physical flag to write |
| wr_pid | input | PID_W | Physical interrupt ID to write |
| ack | input | 1 | Guest acknowledge read |
| deact | input | 1 | Guest deactivate |
| ack_hit | output | 1 | Acknowledge taken this cycle |
| ack_vid | output | VID_W | Acknowledged virtual ID, 0 when no hit |
| slot_valid | output | 1 | Slot holds an interrupt |
| slot_vid | output | VID_W | Stored virtual ID |
| slot_state | output | 2 | Stored lifecycle state |
| slot_link | output | 1 | Stored link flag |
| slot_pid | output | PID_W | Stored physical ID |
| irq_present | output | 1 | Slot offers a pending interrupt to the guest |
| wr_err | output | 1 | One-cycle pulse after a refused write |
| pdeact_req | output | 1 | One-cycle physical deactivate request |
| pdeact_pid | output | PID_W | Physical ID carried with the request |

## Verification
On every cycle the assertions check several rules. A linked valid slot never holds pending+active or a message-range ID. An acknowledge hit is followed by the active state. A refused write keeps the stored fields and pulses the error. A linked retirement is followed by a request with the right physical ID, and an ignored deactivate leaves the state unchanged with no request. Other behaviour needs the bench's scenarios: the same-cycle return of the virtual ID, the write taking priority over guest events, the re-presentation after an unlinked pending+active deactivate, and long random mixes of writes and guest events, all compared against an independent model of the slot.

// File: rtl/vlr_pkg.sv
package vlr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_PEND = 2'b01,
    ST_ACT  = 2'b10,
    ST_PACT = 2'b11
  } vstate_e;

  // A write is acceptable unless it links a slot that is pending+active
  // or links an ID from the message-based range.
  function automatic logic link_ok(input logic link, input vstate_e st,
                                   input logic msg_class);
    return !(link && ((st == ST_PACT) || msg_class));
  endfunction

  // Guest acknowledge: only a pending slot moves on.
  function automatic vstate_e after_ack(input vstate_e st);
    return (st == ST_PEND) ? ST_ACT : st;
  endfunction

  // Guest deactivate: active retires, pending+active drops back to pending.
  function automatic vstate_e after_deact(input vstate_e st);
    case (st)
      ST_ACT:  return ST_IDLE;
      ST_PACT: return ST_PEND;
      default: return st;
    endcase
  endfunction

endpackage

// File: rtl/vlr_wr_check.sv
module vlr_wr_check
  import vlr_pkg::*;
#(
  parameter int VID_W    = 16,
  parameter int LPI_BASE = 8192
) (
  input  logic             wr_en,
  input  logic [VID_W-1:0] wr_vid,
  input  logic [1:0]       wr_state,
  input  logic             wr_link,
  output logic             wr_accept,
  output logic             wr_refuse
);
  localparam logic [VID_W-1:0] MSG_FIRST = VID_W'(LPI_BASE);

  logic msg_class;
  logic legal;

  always_comb begin
    msg_class = (wr_vid >= MSG_FIRST);
    legal     = link_ok(wr_link, vstate_e'(wr_state), msg_class);
    wr_accept = wr_en && legal;
    wr_refuse = wr_en && !legal;
  end

  always_comb begin
    assert_accept_refuse_exclusive_R8: assert (!(wr_accept && wr_refuse));
  end
endmodule

// File: rtl/vlr_guest_fsm.sv
module vlr_guest_fsm
  import vlr_pkg::*;
(
  input  logic    valid,
  input  vstate_e state,
  input  logic    link,
  input  logic    hold,
  input  logic    ack,
  input  logic    deact,
  output logic    ack_hit,
  output logic    deact_hit,
  output logic    deact_linked,
  output logic    upd,
  output vstate_e state_nxt
);
  logic guest_ok;

  always_comb begin
    guest_ok     = valid && !hold;
    ack_hit      = guest_ok && ack && (state == ST_PEND);
    deact_hit    = guest_ok && deact && ((state == ST_ACT) || (state == ST_PACT));
    deact_linked = deact_hit && link && (state == ST_ACT);
    upd          = ack_hit || deact_hit;
    state_nxt    = state;
    if (ack_hit)        state_nxt = after_ack(state);
    else if (deact_hit) state_nxt = after_deact(state);
  end

  always_comb begin
    assert_single_guest_event_R3: assert (!(ack_hit && deact_hit));
  end
endmodule

// File: rtl/vlr_event_out.sv
module vlr_event_out #(
  parameter int PID_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refuse,
  input  logic             retire_linked,
  input  logic [PID_W-1:0] pid,
  output logic             wr_err,
  output logic             pdeact_req,
  output logic [PID_W-1:0] pdeact_pid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_err     <= 1'b0;
      pdeact_req <= 1'b0;
      pdeact_pid <= '0;
    end else begin
      wr_err     <= refuse;
      pdeact_req <= retire_linked;
      pdeact_pid <= retire_linked ? pid : '0;
    end
  end

  assert_pdeact_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pdeact_req |=> !pdeact_req);
  assert_pid_zero_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pdeact_req |-> (pdeact_pid == '0));
endmodule

// File: rtl/vlr_slot.sv
module vlr_slot
  import vlr_pkg::*;
#(
  parameter int VID_W    = 16,
  parameter int PID_W    = 10,
  parameter int LPI_BASE = 8192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_valid,
  input  logic [VID_W-1:0] wr_vid,
  input  logic [1:0]       wr_state,
  input  logic             wr_link,
  input  logic [PID_W-1:0] wr_pid,
  input  logic             ack,
  input  logic             deact,
  output logic             ack_hit,
  output logic [VID_W-1:0] ack_vid,
  output logic             slot_valid,
  output logic [VID_W-1:0] slot_vid,
  output logic [1:0]       slot_state,
  output logic             slot_link,
  output logic [PID_W-1:0] slot_pid,
  output logic             irq_present,
  output logic             wr_err,
  output logic             pdeact_req,
  output logic [PID_W-1:0] pdeact_pid
);
  localparam logic [VID_W-1:0] MSG_FIRST = VID_W'(LPI_BASE);

  logic             r_valid;
  logic [VID_W-1:0] r_vid;
  vstate_e          r_state;
  logic             r_link;
  logic [PID_W-1:0] r_pid;

  // named internal events
  logic    wr_accept;
  logic    wr_refuse;
  logic    deact_hit;
  logic    deact_linked;
  logic    guest_upd;
  vstate_e guest_nxt;

  vlr_wr_check #(.VID_W(VID_W), .LPI_BASE(LPI_BASE)) u_check (
    .wr_en     (wr_en),
    .wr_vid    (wr_vid),
    .wr_state  (wr_state),
    .wr_link   (wr_link),
    .wr_accept (wr_accept),
    .wr_refuse (wr_refuse)
  );

  vlr_guest_fsm u_fsm (
    .valid        (r_valid),
    .state        (r_state),
    .link         (r_link),
    .hold         (wr_en),
    .ack          (ack),
    .deact        (deact),
    .ack_hit      (ack_hit),
    .deact_hit    (deact_hit),
    .deact_linked (deact_linked),
    .upd          (guest_upd),
    .state_nxt    (guest_nxt)
  );

  vlr_event_out #(.PID_W(PID_W)) u_evt (
    .clk           (clk),
    .rst_n         (rst_n),
    .refuse        (wr_refuse),
    .retire_linked (deact_linked),
    .pid           (r_pid),
    .wr_err        (wr_err),
    .pdeact_req    (pdeact_req),
    .pdeact_pid    (pdeact_pid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_valid <= 1'b0;
      r_vid   <= '0;
      r_state <= ST_IDLE;
      r_link  <= 1'b0;
      r_pid   <= '0;
    end else if (wr_accept) begin
      r_valid <= wr_valid;
      r_vid   <= wr_vid;
      r_state <= vstate_e'(wr_state);
      r_link  <= wr_link;
      r_pid   <= wr_pid;
    end else if (guest_upd) begin
      r_state <= guest_nxt;
    end
  end

  always_comb begin
    ack_vid     = ack_hit ? r_vid : '0;
    slot_valid  = r_valid;
    slot_vid    = r_vid;
    slot_state  = r_state;
    slot_link   = r_link;
    slot_pid    = r_pid;
    irq_present = r_valid && (r_state == ST_PEND);
  end

  // ---- assertions beside the slot register ----
  assert_link_never_pact_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && r_link) |-> (r_state != ST_PACT));
  assert_link_never_msg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && r_link) |-> (r_vid < MSG_FIRST));
  assert_ack_to_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> (r_state == ST_ACT));
  assert_refuse_keeps_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_refuse |=> (wr_err && $stable(r_state) && $stable(r_vid) && $stable(r_pid)
                   && $stable(r_link) && $stable(r_valid)));
  assert_linked_retire_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    deact_linked |=> (pdeact_req && (pdeact_pid == $past(r_pid)) && (r_state == ST_IDLE)));
  assert_pact_back_to_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (deact_hit && r_state == ST_PACT) |=> (r_state == ST_PEND && irq_present));
  assert_ignored_deact_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (deact && !ack && !wr_en && (r_state == ST_IDLE || r_state == ST_PEND))
      |=> (!pdeact_req && $stable(r_state)));
  assert_write_blocks_guest_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!ack_hit && !deact_hit));
endmodule

// File: tb/vlr_slot_tb.sv
module vlr_slot_tb;
  localparam int VID_W = 16;
  localparam int PID_W = 10;
  localparam int LPI_BASE = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_valid = 0, wr_link = 0, ack = 0, deact = 0;
  logic [VID_W-1:0] wr_vid = '0;
  logic [1:0] wr_state = '0;
  logic [PID_W-1:0] wr_pid = '0;
  logic ack_hit, slot_valid, slot_link, irq_present, wr_err, pdeact_req;
  logic [VID_W-1:0] ack_vid, slot_vid;
  logic [1:0] slot_state;
  logic [PID_W-1:0] slot_pid, pdeact_pid;

  always #2.5 clk = ~clk;

  vlr_slot #(.VID_W(VID_W), .PID_W(PID_W), .LPI_BASE(LPI_BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_valid(wr_valid), .wr_vid(wr_vid),
    .wr_state(wr_state), .wr_link(wr_link), .wr_pid(wr_pid), .ack(ack), .deact(deact),
    .ack_hit(ack_hit), .ack_vid(ack_vid), .slot_valid(slot_valid), .slot_vid(slot_vid),
    .slot_state(slot_state), .slot_link(slot_link), .slot_pid(slot_pid),
    .irq_present(irq_present), .wr_err(wr_err), .pdeact_req(pdeact_req),
    .pdeact_pid(pdeact_pid));

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // independent model of the slot
  bit m_valid, m_link;
  bit [VID_W-1:0] m_vid;
  bit [1:0] m_state;
  bit [PID_W-1:0] m_pid;

  function automatic bit refused(bit link, bit [1:0] st, bit [VID_W-1:0] vid);
    bit bad_pair = (st == 2'd3);
    bit bad_msg  = (int'(vid) >= LPI_BASE);
    return link & (bad_pair | bad_msg);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pack_slot(logic v, logic [VID_W-1:0] id, logic [1:0] st,
                                            logic l, logic [PID_W-1:0] p, logic pr);
    return {33'd0, v, id, st, l, p, pr};
  endfunction

  // one cycle: drive at negedge, check comb, then registered at next negedge
  task automatic step(bit w, bit wv, bit [VID_W-1:0] wid, bit [1:0] wst, bit wl,
                      bit [PID_W-1:0] wp, bit a, bit d);
    bit e_hit, e_err, e_req;
    bit [PID_W-1:0] e_pid;
    string tag;
    wr_en = w; wr_valid = wv; wr_vid = wid; wr_state = wst; wr_link = wl; wr_pid = wp;
    ack = a; deact = d;
    e_hit = !w && a && m_valid && (m_state == 2'd1);
    e_err = 0; e_req = 0; e_pid = '0;
    tag = w ? ((a || d) ? "R10" : (refused(wl, wst, wid) ? ((wst == 2'd3) ? "R8" : "R9") : "R2"))
            : (a ? "R3" : "R6");
    #1;
    check(e_hit ? "R3" : tag, {62'd0, ack_hit, 1'b0} | 64'(ack_vid) << 2,
          {62'd0, e_hit, 1'b0} | 64'(e_hit ? m_vid : '0) << 2);
    if (w) begin
      if (refused(wl, wst, wid)) e_err = 1;
      else begin
        m_valid = wv; m_vid = wid; m_state = wst; m_link = wl; m_pid = wp;
      end
    end else if (m_valid) begin
      if (e_hit) m_state = 2'd2;
      else if (d && m_state == 2'd2) begin
        tag = m_link ? "R7" : "R4";
        e_req = m_link; e_pid = m_link ? m_pid : '0;
        m_state = 2'd0;
      end else if (d && m_state == 2'd3) begin
        tag = "R5"; m_state = 2'd1;
      end
    end
    @(negedge clk);
    check(tag, pack_slot(slot_valid, slot_vid, slot_state, slot_link, slot_pid, irq_present),
          pack_slot(m_valid, m_vid, m_state, m_link, m_pid, m_valid && m_state == 2'd1));
    check(e_err ? tag : "R8", {63'd0, wr_err}, {63'd0, e_err});
    check("R7", {53'd0, pdeact_req, pdeact_pid}, {53'd0, e_req, e_pid});
  endtask

  initial begin
    m_valid = 0; m_link = 0; m_vid = '0; m_state = '0; m_pid = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {43'd0, slot_valid, slot_state, slot_link, slot_vid},
          64'd0);
    check("R1", {59'd0, slot_pid == '0, irq_present, ack_hit, wr_err, pdeact_req}, 64'h10);
    rst_n = 1;
    @(negedge clk);
    // directed corners
    step(1, 1, 16'd5, 2'd1, 1, 10'd33, 0, 0);   // R2 linked pending
    step(0, 0, 0, 0, 0, 0, 1, 0);              // R3 ack
    step(0, 0, 0, 0, 0, 0, 1, 0);              // R3 second ack ignored
    step(0, 0, 0, 0, 0, 0, 0, 1);              // R7 linked retire
    step(0, 0, 0, 0, 0, 0, 0, 1);              // R6 deact while inactive
    step(1, 1, 16'd7, 2'd3, 1, 10'd9, 0, 0);   // R8 refused
    step(1, 1, 16'd9000, 2'd1, 1, 10'd9, 0, 0);// R9 refused
    step(1, 1, 16'd9000, 2'd1, 0, 10'd9, 0, 0);// R2 unlinked message id accepted
    step(0, 0, 0, 0, 0, 0, 0, 1);              // R6 deact while pending
    step(1, 1, 16'd12, 2'd3, 0, 10'd4, 0, 0);  // R2 unlinked pending+active
    step(0, 0, 0, 0, 0, 0, 1, 0);              // R3 ack ignored in pact
    step(0, 0, 0, 0, 0, 0, 0, 1);              // R5 back to pending
    step(1, 1, 16'd12, 2'd1, 0, 10'd4, 1, 0);  // R10 write with ack
    step(1, 1, 16'd13, 2'd2, 1, 10'd4, 0, 1);  // R10 write with deact
    step(0, 0, 0, 0, 0, 0, 0, 1);              // R7 retire pid 4
    step(1, 1, 16'd14, 2'd2, 0, 10'd4, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1);              // R4 unlinked retire, no request
    // constrained random
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 99);
      bit w = (op < 25);
      bit a = (op >= 25 && op < 60) || (op >= 95);
      bit d = (op >= 55 && op < 90) || (op >= 97);
      bit [1:0] st = 2'($urandom_range(0, 3));
      bit [VID_W-1:0] vid = ($urandom_range(0, 3) == 0) ? VID_W'($urandom_range(LPI_BASE, 65535))
                                                        : VID_W'($urandom_range(0, LPI_BASE-1));
      step(w, ($urandom_range(0, 7) != 0), vid, st, 1'($urandom_range(0, 1)),
           PID_W'($urandom), a, d);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule